// File: doc/BRIEF.md
# Channel Pulse Mode and Dead-Time Controller

This block models the digital output logic of one readout channel. It watches a registered discriminator hit and a run-down comparator input. It then drives a single channel output in one of two encodings, chosen by a chip-level mode bit. In time-over-threshold encoding the output simply follows the hit. In charge-encoding (ADC) mode a rising hit starts a pulse. The pulse's leading edge marks the hit time. Its width is a counted integration gate plus a run-down phase that lasts until the comparator drops or a width cap is reached.

After every ADC pulse the block enforces a programmable dead time. A hit that arrives during the dead time is discarded, and a sticky flag records the loss. A two-bit override can replace the final output with a constant high or low while the internal machine keeps running. The gate and dead-time codes are turned into cycle counts with a base-plus-step rule. Both the base and the step are parameters.

The interface has no data stream, so every pin is a plain level and there is no valid/ready handshake or back-pressure. Codes and the mode bit are sampled when a hit is accepted.

Top module: `chan_pulse_ctrl`

## Requirements
- R1: After reset, with override code 00, the channel output is low and the dropped-hit flag is low.
- R2: With the mode bit low (time-over-threshold), the output rises one cycle after the hit input is first sampled high, and it stays high for exactly as many cycles as the hit input is held high.
- R3: With the mode bit high, a rising hit edge sampled in idle starts a pulse on the next cycle. The integration gate lasts G = GATE_BASE + gate_code * GATE_STEP cycles (defaults 3 and 1).
- R4: After the gate, the output stays high through a run-down phase of at least one cycle. It falls once the run-down input is sampled low, so the pulse width equals G plus the number of run-down cycles.
- R5: If the run-down input stays high, the run-down phase ends after RUND_MAX cycles (default 10), giving a width of G + RUND_MAX.
- R6: Once an ADC pulse falls, the block waits D = DEAD_BASE + dead_code * DEAD_STEP clock edges (defaults 6 and 2). A rising hit edge sampled at any of these D edges is ignored and produces no output. A rising hit edge on the following edge is accepted.
- R7: Every hit ignored under R6 sets the dropped-hit flag, which then stays high until reset.
- R8: In ADC mode only a rising hit edge starts a pulse. A hit held high through the pulse and the dead time does not trigger a second pulse.
- R9: Override code 01 forces the output high and code 10 forces it low, whatever the internal pulse state. Codes 00 and 11 pass the internal pulse through.
- R10: While the output is forced, the internal machine keeps running. Releasing the override in the middle of an ADC gate shows the output high at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock for all counts |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_i | input | 1 | Registered discriminator hit |
| rundown_i | input | 1 | Run-down comparator, high while charge remains |
| adc_mode_i | input | 1 | 0: time-over-threshold, 1: ADC encoding |
| gate_code_i | input | GCODE_W (4) | Integration gate code |
| dead_code_i | input | DCODE_W (3) | Dead-time code |
| out_mode_i | input | 2 | Output override: 00/11 active, 01 high, 10 low |
| chan_o | output | 1 | Channel output |
| drop_seen_o | output | 1 | Sticky flag: a hit was dropped in dead time |

## Verification
The bench probes the dead-time edge from both sides. A hit on the last blocked edge must be dropped and must set the flag. A hit one edge later must produce a pulse. A dead-time counter that is off by one cycle fails one of these two probes. The bench also pulls run-down low in mid-phase, holds it high to hit the width cap, and uses the smallest and largest gate codes. A wrong count term or a missing minimum run-down cycle then shows up as a wrong pulse width. A held hit exposes a level-triggered ADC start, which would retrigger after the dead time. Releasing the override during a gate catches a machine that was frozen while the output was forced.

// File: rtl/chpc_pkg.sv
package chpc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_TOT  = 3'd1,
    ST_GATE = 3'd2,
    ST_RUND = 3'd3,
    ST_DEAD = 3'd4
  } chpc_state_e;

  typedef enum logic [1:0] {
    OM_ACTIVE  = 2'b00,
    OM_HIGH    = 2'b01,
    OM_LOW     = 2'b10,
    OM_ACTIVE2 = 2'b11
  } chpc_omode_e;
endpackage

// File: rtl/chpc_dur_calc.sv
module chpc_dur_calc #(
  parameter int CODE_W = 4,
  parameter int BASE   = 3,
  parameter int STEP   = 1,
  parameter int OUT_W  = 8
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [OUT_W-1:0]  cycles_o
);
  // Duration in reference-clock cycles: base plus code times step.
  always_comb begin
    cycles_o = OUT_W'(BASE) + OUT_W'(STEP) * OUT_W'(code_i);
  end
endmodule

// File: rtl/chpc_fsm.sv
module chpc_fsm
  import chpc_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int RUND_MAX = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit_i,
  input  logic             rundown_i,
  input  logic             adc_mode_i,
  input  logic [CNT_W-1:0] gate_cyc_i,
  input  logic [CNT_W-1:0] dead_cyc_i,
  output logic             pulse_o,
  output logic             drop_o,
  output chpc_state_e      state_o
);
  chpc_state_e      state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             hit_d_q;
  logic             hit_rise;

  assign hit_rise = hit_i & ~hit_d_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      hit_d_q <= 1'b0;
      drop_o  <= 1'b0;
    end else begin
      hit_d_q <= hit_i;
      case (state_q)
        ST_IDLE: begin
          if (adc_mode_i) begin
            if (hit_rise) begin
              state_q <= ST_GATE;
              cnt_q   <= gate_cyc_i - CNT_W'(1);
            end
          end else if (hit_i) begin
            state_q <= ST_TOT;
          end
        end
        ST_TOT: begin
          if (!hit_i) state_q <= ST_IDLE;
        end
        ST_GATE: begin
          if (cnt_q == '0) begin
            state_q <= ST_RUND;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        ST_RUND: begin
          if (!rundown_i || cnt_q == CNT_W'(RUND_MAX - 1)) begin
            state_q <= ST_DEAD;
            cnt_q   <= dead_cyc_i - CNT_W'(1);
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        ST_DEAD: begin
          if (hit_rise) drop_o <= 1'b1;
          if (cnt_q == '0) state_q <= ST_IDLE;
          else             cnt_q   <= cnt_q - CNT_W'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign pulse_o = (state_q == ST_TOT) || (state_q == ST_GATE) || (state_q == ST_RUND);
  assign state_o = state_q;
endmodule

// File: rtl/chpc_out_stage.sv
module chpc_out_stage
  import chpc_pkg::*;
(
  input  logic [1:0] out_mode_i,
  input  logic       pulse_i,
  output logic       chan_o
);
  always_comb begin
    case (chpc_omode_e'(out_mode_i))
      OM_HIGH: chan_o = 1'b1;
      OM_LOW:  chan_o = 1'b0;
      default: chan_o = pulse_i;
    endcase
  end
endmodule

// File: rtl/chan_pulse_ctrl.sv
module chan_pulse_ctrl
  import chpc_pkg::*;
#(
  parameter int GCODE_W   = 4,
  parameter int DCODE_W   = 3,
  parameter int GATE_BASE = 3,
  parameter int GATE_STEP = 1,
  parameter int DEAD_BASE = 6,
  parameter int DEAD_STEP = 2,
  parameter int RUND_MAX  = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hit_i,
  input  logic               rundown_i,
  input  logic               adc_mode_i,
  input  logic [GCODE_W-1:0] gate_code_i,
  input  logic [DCODE_W-1:0] dead_code_i,
  input  logic [1:0]         out_mode_i,
  output logic               chan_o,
  output logic               drop_seen_o
);
  localparam int GATE_MAX = GATE_BASE + ((1 << GCODE_W) - 1) * GATE_STEP;
  localparam int DEAD_MAX = DEAD_BASE + ((1 << DCODE_W) - 1) * DEAD_STEP;
  localparam int MAX_GD   = (GATE_MAX > DEAD_MAX) ? GATE_MAX : DEAD_MAX;
  localparam int MAX_ALL  = (MAX_GD > RUND_MAX) ? MAX_GD : RUND_MAX;
  localparam int CNT_W    = $clog2(MAX_ALL + 1);

  logic [CNT_W-1:0] gate_cyc;
  logic [CNT_W-1:0] dead_cyc;
  logic             pulse;
  chpc_state_e      fsm_state;

  chpc_dur_calc #(.CODE_W(GCODE_W), .BASE(GATE_BASE), .STEP(GATE_STEP), .OUT_W(CNT_W))
    i_gate_dur (.code_i(gate_code_i), .cycles_o(gate_cyc));

  chpc_dur_calc #(.CODE_W(DCODE_W), .BASE(DEAD_BASE), .STEP(DEAD_STEP), .OUT_W(CNT_W))
    i_dead_dur (.code_i(dead_code_i), .cycles_o(dead_cyc));

  chpc_fsm #(.CNT_W(CNT_W), .RUND_MAX(RUND_MAX)) i_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .hit_i      (hit_i),
    .rundown_i  (rundown_i),
    .adc_mode_i (adc_mode_i),
    .gate_cyc_i (gate_cyc),
    .dead_cyc_i (dead_cyc),
    .pulse_o    (pulse),
    .drop_o     (drop_seen_o),
    .state_o    (fsm_state)
  );

  chpc_out_stage i_out (
    .out_mode_i (out_mode_i),
    .pulse_i    (pulse),
    .chan_o     (chan_o)
  );
endmodule

// File: rtl/chpc_checker.sv
module chpc_checker
  import chpc_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        hit_i,
  input logic        rundown_i,
  input logic [1:0]  out_mode_i,
  input logic        chan_o,
  input chpc_state_e state,
  input logic        drop
);
  logic hit_prev;
  always_ff @(posedge clk) begin
    if (!rst_n) hit_prev <= 1'b0;
    else        hit_prev <= hit_i;
  end

  AST_TOT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TOT && !hit_i) |=> (state == ST_IDLE)); // R2

  AST_GATE_NO_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_GATE) |=> (state == ST_GATE || state == ST_RUND)); // R3

  AST_RUND_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUND && !rundown_i) |=> (state == ST_DEAD)); // R4

  AST_DEAD_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DEAD) |=> (state != ST_GATE)); // R6

  AST_DROP_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DEAD && hit_i && !hit_prev) |=> drop); // R7

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> drop); // R7

  AST_FORCE_LOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_mode_i == 2'b10 && $stable(out_mode_i)) |-> !chan_o); // R9
endmodule

bind chan_pulse_ctrl chpc_checker i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .hit_i      (hit_i),
  .rundown_i  (rundown_i),
  .out_mode_i (out_mode_i),
  .chan_o     (chan_o),
  .state      (fsm_state),
  .drop       (drop_seen_o)
);

// File: tb/test_chan_pulse_ctrl.sv
module test_chan_pulse_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hit_i = 1'b0;
  logic       rundown_i = 1'b0;
  logic       adc_mode_i = 1'b0;
  logic [3:0] gate_code_i = '0;
  logic [2:0] dead_code_i = '0;
  logic [1:0] out_mode_i = 2'b00;
  logic       chan_o;
  logic       drop_seen_o;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  chan_pulse_ctrl i_chan_pulse_ctrl (
    .clk(clk), .rst_n(rst_n), .hit_i(hit_i), .rundown_i(rundown_i),
    .adc_mode_i(adc_mode_i), .gate_code_i(gate_code_i), .dead_code_i(dead_code_i),
    .out_mode_i(out_mode_i), .chan_o(chan_o), .drop_seen_o(drop_seen_o)
  );

  typedef struct packed {
    logic       adc;
    logic [3:0] g;
    logic [2:0] d;
    logic       rd;
    logic [7:0] hlen;
    logic [7:0] exp_w;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 4'd0,  3'd0, 1'b0, 8'd5,  8'd5},   // R2
    '{1'b0, 4'd0,  3'd0, 1'b0, 8'd12, 8'd12},  // R2
    '{1'b0, 4'd0,  3'd0, 1'b0, 8'd1,  8'd1},   // R2
    '{1'b1, 4'd0,  3'd0, 1'b0, 8'd1,  8'd4},   // R3 min gate 3 + 1
    '{1'b1, 4'd4,  3'd1, 1'b0, 8'd1,  8'd8},   // R3 gate 7 + 1
    '{1'b1, 4'd15, 3'd7, 1'b0, 8'd1,  8'd19},  // R3 max gate 18 + 1
    '{1'b1, 4'd0,  3'd0, 1'b1, 8'd1,  8'd13},  // R5 3 + 10
    '{1'b1, 4'd7,  3'd2, 1'b1, 8'd1,  8'd20},  // R5 10 + 10
    '{1'b1, 4'd2,  3'd0, 1'b0, 8'd30, 8'd6}    // R8 held hit, one pulse only
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Launch a hit at a negedge, then count high output samples over a window.
  task automatic run_pulse(input logic adc, input logic [3:0] g, input logic [2:0] d,
                           input logic rd, input int hlen, input int drop_at,
                           output int width);
    @(negedge clk);
    adc_mode_i = adc; gate_code_i = g; dead_code_i = d; rundown_i = rd;
    hit_i = 1'b1;
    width = 0;
    for (int i = 1; i <= 80; i++) begin
      @(negedge clk);
      if (i == hlen) hit_i = 1'b0;
      if (chan_o) width++;
      if (i == drop_at) rundown_i = 1'b0;
    end
    rundown_i = 1'b0;
  endtask

  // ADC pulse with gate 3, run-down 1, dead code 3 (D = 12); second hit at fall + j.
  task automatic dead_probe(input int j, output logic out_seen, output logic flag_seen);
    @(negedge clk);
    adc_mode_i = 1'b1; gate_code_i = 4'd0; dead_code_i = 3'd3; rundown_i = 1'b0;
    hit_i = 1'b1;
    out_seen = 1'b0; flag_seen = 1'b0;
    for (int i = 1; i <= 60; i++) begin
      @(negedge clk);
      if (i == 1) hit_i = 1'b0;
      if (i == 5 + j) hit_i = 1'b1;
      if (i == 6 + j) begin
        hit_i = 1'b0;
        out_seen = chan_o;
        flag_seen = drop_seen_o;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int w;
    logic o, f;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 out after reset", chan_o, 0);
    check("R1 flag after reset", drop_seen_o, 0);

    for (int k = 0; k < NV; k++) begin
      run_pulse(VEC[k].adc, VEC[k].g, VEC[k].d, VEC[k].rd, int'(VEC[k].hlen), 0, w);
      check(!VEC[k].adc ? "R2 tot width" : (VEC[k].hlen > 1) ? "R8 held hit width"
            : VEC[k].rd ? "R5 capped width" : "R3 gate width", w, int'(VEC[k].exp_w));
    end

    // R4: run-down drops after two run-down cycles -> width 3 + 2
    run_pulse(1'b1, 4'd0, 3'd0, 1'b1, 1, 5, w);
    check("R4 rundown release width", w, 5);

    // R6: first edge after dead time accepts
    dead_probe(12, o, f);
    check("R6 hit after dead accepted", o, 1);
    check("R7 flag stays low", f, 0);
    // R6/R7: last dead edge drops and flags
    dead_probe(11, o, f);
    check("R6 hit in dead ignored", o, 0);
    check("R7 flag set on drop", f, 1);
    @(negedge clk);
    check("R7 flag sticky", drop_seen_o, 1);

    // R9: overrides in idle
    @(negedge clk);
    out_mode_i = 2'b01; #1;
    check("R9 force high", chan_o, 1);
    out_mode_i = 2'b11; #1;
    check("R9 code 11 passes idle low", chan_o, 0);

    // R9/R10: force low during ADC gate, then release
    @(negedge clk);
    out_mode_i = 2'b10;
    adc_mode_i = 1'b1; gate_code_i = 4'd15; dead_code_i = 3'd0; rundown_i = 1'b0;
    hit_i = 1'b1;
    @(negedge clk); hit_i = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R9 force low during pulse", chan_o, 0);
    out_mode_i = 2'b00; #1;
    check("R10 machine ran under override", chan_o, 1);
    repeat (60) @(negedge clk);
    check("R9 active idle after pulse", chan_o, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule